// File: doc/BRIEF.md
# TMDS Lane Symbol Encoder

This block encodes one colour lane of a DVI-style video link. On every pixel clock it takes an 8-bit colour component, a video-enable flag and two sync bits, and it produces one 10-bit line symbol. A 10:1 serialiser then shifts the symbol out at ten times the pixel rate. A transmitter uses three copies of the block, one each for red, green and blue. On the lane that carries them, the two sync bits are horizontal and vertical sync.

While video is enabled, the byte goes through a two-step code. The first step chooses XOR or XNOR chaining to cut the number of bit transitions. The second step inverts the word when that brings a signed running disparity closer to zero. While video is disabled, the lane sends one of four fixed control tokens, selected by the sync bits. Nothing else is sent in blanking. The path is two registers deep, and the enable and sync bits travel alongside the data so that all of them stay aligned.

Top module: `tmds_lane_encoder`

## Requirements
- R1: While reset is high, and on the first clock after it, `tmds_sym` equals the token 10'b1101010100 and the running disparity is zero.
- R2: An input presented before clock edge k shows on `tmds_sym` after edge k+1. This two-clock delay applies equally to pixel data, `vid_en` and `sync_bits`.
- R3: With `vid_en` low, `tmds_sym` (bit 9 written leftmost, bit 0 sent first) is 10'b1101010100 for sync 00, 10'b0010101011 for 01, 10'b0101010100 for 10 and 10'b1010101011 for 11. `pix_byte` has no effect in this case.
- R4: Stage one counts the ones in the byte. It uses XNOR chaining when the count is above 4, or when the count is exactly 4 and bit 0 is 0. In every other case it uses XOR chaining. The original byte can be recovered from the symbol.
- R5: In a data symbol, bit 8 is 1 for XOR chaining and 0 for XNOR chaining. Bit 9 is 1 exactly when bits 7:0 hold the inverted chained word.
- R6: The running disparity equals the sum of (ones minus zeros) over the data symbols sent since the last blanking symbol. It always stays even and within -8..+8.
- R7: The disparity is cleared whenever a blanking symbol is produced. In the first data symbol after blanking, bit 9 is therefore the complement of bit 8.
- R8: When the disparity is nonzero and the chained word is unbalanced, the word is inverted if and only if its bias has the same sign as the disparity.
- R9: While `vid_en` is high, `sync_bits` has no effect on `tmds_sym`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_en | input | 1 | High during active video, low during blanking |
| sync_bits | input | 2 | Control bits (sync) that select the blanking token |
| pix_byte | input | 8 | Colour component for this pixel |
| tmds_sym | output | 10 | Encoded line symbol, bit 0 sent first |

## Verification
Some properties are checked by assertions on every cycle. These are: the token that follows blanking two clocks later, the reset token, the disparity range and parity, the clearing of the disparity behind a blanking slot, chained bit 0 equal to the byte's bit 0, and the flag and inversion fields of each data symbol matching the word from stage one. Other behaviour can only be shown by the bench's scenarios, which compare every symbol against a model written independently of the RTL. These are: whether each inversion decision is correct, whether the accumulated disparity over a stream of symbols is right, whether each symbol decodes back to its byte, and whether the output stays unchanged when the bits that should be ignored are varied.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;
  localparam int BYTE_W = 8;
  localparam int QM_W   = BYTE_W + 1;
  localparam int SYM_W  = QM_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int HALF_W = BYTE_W / 2;

  localparam logic [SYM_W-1:0] TOK_S0 = 10'b1101010100;
  localparam logic [SYM_W-1:0] TOK_S1 = 10'b0010101011;
  localparam logic [SYM_W-1:0] TOK_S2 = 10'b0101010100;
  localparam logic [SYM_W-1:0] TOK_S3 = 10'b1010101011;

  // population count of one byte
  function automatic logic [CNT_W-1:0] ones_in(input logic [BYTE_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < BYTE_W; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  // blanking token for a pair of sync bits
  function automatic logic [SYM_W-1:0] ctl_token(input logic [1:0] c);
    logic [SYM_W-1:0] t;
    case (c)
      2'b00:   t = TOK_S0;
      2'b01:   t = TOK_S1;
      2'b10:   t = TOK_S2;
      default: t = TOK_S3;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/tmds_xmin_stage.sv
module tmds_xmin_stage
  import tmds_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              de_i,
  input  logic [1:0]        ctl_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              de_o,
  output logic [1:0]        ctl_o,
  output logic [QM_W-1:0]   qm_o,
  output logic              use_xnor_o
);
  logic [CNT_W-1:0]  n_ones;
  logic [BYTE_W-1:0] chain_x;
  logic [BYTE_W-1:0] chain_n;
  logic              use_xnor;
  logic [QM_W-1:0]   qm_nx;

  assign n_ones   = ones_in(byte_i);
  assign use_xnor = (n_ones > CNT_W'(HALF_W)) ||
                    ((n_ones == CNT_W'(HALF_W)) && !byte_i[0]);

  assign chain_x[0] = byte_i[0];
  assign chain_n[0] = byte_i[0];
  for (genvar i = 1; i < BYTE_W; i++) begin : g_chain
    assign chain_x[i] = chain_x[i-1] ^ byte_i[i];
    assign chain_n[i] = ~(chain_n[i-1] ^ byte_i[i]);
  end

  assign qm_nx      = use_xnor ? {1'b0, chain_n} : {1'b1, chain_x};
  assign use_xnor_o = use_xnor;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o  <= 1'b0;
      ctl_o <= 2'b00;
      qm_o  <= '0;
    end else begin
      de_o  <= de_i;
      ctl_o <= ctl_i;
      qm_o  <= qm_nx;
    end
  end
endmodule

// File: rtl/tmds_ctl_token.sv
module tmds_ctl_token
  import tmds_enc_pkg::*;
(
  input  logic [1:0]       ctl_i,
  output logic [SYM_W-1:0] tok_o
);
  assign tok_o = ctl_token(ctl_i);
endmodule

// File: rtl/tmds_dcbal_stage.sv
module tmds_dcbal_stage
  import tmds_enc_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     de_i,
  input  logic [1:0]               ctl_i,
  input  logic [QM_W-1:0]          qm_i,
  output logic [SYM_W-1:0]         sym_o,
  output logic signed [DISP_W-1:0] disp_o,
  output logic                     invert_o
);
  localparam logic signed [DISP_W-1:0] WORD_LEN = DISP_W'(BYTE_W);
  localparam logic signed [DISP_W-1:0] TWO      = DISP_W'(2);

  logic [CNT_W-1:0]          n1;
  logic signed [DISP_W-1:0]  twice_ones, bias;
  logic signed [DISP_W-1:0]  disp_q, disp_nx;
  logic [SYM_W-1:0]          sym_q, sym_nx, tok;
  logic                      flag;
  logic                      disp_zero, disp_neg, bias_zero, bias_neg;
  logic                      invert;

  tmds_ctl_token u_tok (.ctl_i(ctl_i), .tok_o(tok));

  assign n1         = ones_in(qm_i[BYTE_W-1:0]);
  assign twice_ones = $signed(DISP_W'({n1, 1'b0}));
  assign bias       = twice_ones - WORD_LEN;
  assign flag       = qm_i[BYTE_W];
  assign disp_zero  = (disp_q == '0);
  assign disp_neg   = disp_q[DISP_W-1];
  assign bias_zero  = (bias == '0);
  assign bias_neg   = bias[DISP_W-1];

  always_comb begin
    sym_nx  = tok;
    disp_nx = '0;
    invert  = 1'b0;
    if (de_i) begin
      if (disp_zero || bias_zero) begin
        invert  = !flag;
        disp_nx = flag ? (disp_q + bias) : (disp_q - bias);
      end else if (disp_neg == bias_neg) begin
        invert  = 1'b1;
        disp_nx = disp_q - bias + (flag ? TWO : '0);
      end else begin
        invert  = 1'b0;
        disp_nx = disp_q + bias - (flag ? '0 : TWO);
      end
      sym_nx = {invert, flag, invert ? ~qm_i[BYTE_W-1:0] : qm_i[BYTE_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q  <= TOK_S0;
      disp_q <= '0;
    end else begin
      sym_q  <= sym_nx;
      disp_q <= disp_nx;
    end
  end

  assign sym_o    = sym_q;
  assign disp_o   = disp_q;
  assign invert_o = invert;
endmodule

// File: rtl/tmds_lane_encoder.sv
module tmds_lane_encoder
  import tmds_enc_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vid_en,
  input  logic [1:0]       sync_bits,
  input  logic [7:0]       pix_byte,
  output logic [9:0]       tmds_sym
);
  // named internal events, observed by the bound checker
  logic                     de_q1;
  logic [1:0]               ctl_q1;
  logic [QM_W-1:0]          qm_q1;
  logic                     xnor_sel;
  logic signed [DISP_W-1:0] disp_q;
  logic                     invert_data;

  tmds_xmin_stage u_xmin (
    .clk(clk), .rst(rst),
    .de_i(vid_en), .ctl_i(sync_bits), .byte_i(pix_byte),
    .de_o(de_q1), .ctl_o(ctl_q1), .qm_o(qm_q1), .use_xnor_o(xnor_sel)
  );

  tmds_dcbal_stage #(.DISP_W(DISP_W)) u_dcbal (
    .clk(clk), .rst(rst),
    .de_i(de_q1), .ctl_i(ctl_q1), .qm_i(qm_q1),
    .sym_o(tmds_sym), .disp_o(disp_q), .invert_o(invert_data)
  );
endmodule

// File: rtl/tmds_lane_encoder_chk.sv
module tmds_lane_encoder_chk
  import tmds_enc_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     vid_en,
  input logic [1:0]               sync_bits,
  input logic [7:0]               pix_byte,
  input logic [9:0]               tmds_sym,
  input logic                     de_q1,
  input logic [QM_W-1:0]          qm_q1,
  input logic signed [DISP_W-1:0] disp_q
);
  localparam logic signed [DISP_W-1:0] LIM_HI = DISP_W'(BYTE_W);
  localparam logic signed [DISP_W-1:0] LIM_LO = -DISP_W'(BYTE_W);

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_reset_token_R1: assert property (@(posedge clk)
    rst |=> (tmds_sym == TOK_S0 && disp_q == '0));

  assert_blank_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && !$past(vid_en, 2)) |-> (tmds_sym == ctl_token($past(sync_bits, 2))));

  assert_chain_lsb_R4: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd1 && $past(vid_en)) |-> (de_q1 && qm_q1[0] == $past(pix_byte[0])));

  assert_flag_field_R5: assert property (@(posedge clk) disable iff (rst)
    de_q1 |=> (tmds_sym[8] == $past(qm_q1[8]) &&
               (tmds_sym[7:0] ^ {8{tmds_sym[9]}}) == $past(qm_q1[7:0])));

  assert_disp_range_R6: assert property (@(posedge clk) disable iff (rst)
    (disp_q <= LIM_HI && disp_q >= LIM_LO && !disp_q[0]));

  assert_disp_clear_R7: assert property (@(posedge clk) disable iff (rst)
    !de_q1 |=> (disp_q == '0));
endmodule

bind tmds_lane_encoder tmds_lane_encoder_chk #(.DISP_W(DISP_W)) u_chk (
  .clk(clk), .rst(rst), .vid_en(vid_en), .sync_bits(sync_bits),
  .pix_byte(pix_byte), .tmds_sym(tmds_sym), .de_q1(de_q1),
  .qm_q1(qm_q1), .disp_q(disp_q)
);

// File: tb/sim_tmds_lane_encoder.sv
`timescale 1ns/1ps
module sim_tmds_lane_encoder;
  logic       clk = 1'b0;
  logic       rst;
  logic       vid_en;
  logic [1:0] sync_bits;
  logic [7:0] pix_byte;
  logic [9:0] tmds_sym;

  int checks = 0;
  int errors = 0;
  int run_disp = 0;   // model disparity
  int seen_disp = 0;  // disparity accumulated from observed symbols
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmds_lane_encoder u0 (
    .clk(clk), .rst(rst), .vid_en(vid_en), .sync_bits(sync_bits),
    .pix_byte(pix_byte), .tmds_sym(tmds_sym)
  );

  // {vid_en, sync_bits, pix_byte}
  localparam int NV = 24;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'b00, 8'h5A}, {1'b0, 2'b01, 8'hFF}, {1'b0, 2'b10, 8'h00}, {1'b0, 2'b11, 8'hC3},
    {1'b1, 2'b00, 8'h00}, {1'b1, 2'b11, 8'hFF}, {1'b1, 2'b01, 8'hFF}, {1'b1, 2'b10, 8'hFF},
    {1'b1, 2'b00, 8'h10}, {1'b1, 2'b00, 8'h55}, {1'b1, 2'b00, 8'hAA}, {1'b1, 2'b11, 8'h0F},
    {1'b1, 2'b00, 8'hF0}, {1'b1, 2'b00, 8'h01}, {1'b1, 2'b00, 8'h80}, {1'b1, 2'b00, 8'h7E},
    {1'b1, 2'b00, 8'hFE}, {1'b1, 2'b01, 8'h3C}, {1'b1, 2'b00, 8'hE1}, {1'b0, 2'b01, 8'h99},
    {1'b1, 2'b00, 8'hFF}, {1'b1, 2'b00, 8'hFF}, {1'b0, 2'b10, 8'hFF}, {1'b0, 2'b11, 8'h00}
  };

  function automatic logic [9:0] b_token(input logic [1:0] c);
    if (c == 2'b00) return 10'b1101010100;
    if (c == 2'b01) return 10'b0010101011;
    if (c == 2'b10) return 10'b0101010100;
    return 10'b1010101011;
  endfunction

  function automatic logic [8:0] b_chain(input logic [7:0] d);
    int n;
    logic xn;
    logic [8:0] q;
    n = $countones(d);
    xn = (n > 4) || (n == 4 && d[0] == 1'b0);
    q[0] = d[0];
    for (int i = 1; i < 8; i++) q[i] = xn ? (q[i-1] ~^ d[i]) : (q[i-1] ^ d[i]);
    q[8] = !xn;
    return q;
  endfunction

  function automatic logic [7:0] b_decode(input logic [9:0] s);
    logic [7:0] w, d;
    w = s[9] ? ~s[7:0] : s[7:0];
    d[0] = w[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (w[i] ^ w[i-1]) : (w[i] ~^ w[i-1]);
    return d;
  endfunction

  // model: one symbol, updates run_disp
  task automatic model_sym(input logic de, input logic [1:0] c, input logic [7:0] d,
                           output logic [9:0] s);
    logic [8:0] q;
    int bias;
    logic inv;
    if (!de) begin
      s = b_token(c);
      run_disp = 0;
    end else begin
      q = b_chain(d);
      bias = 2 * $countones(q[7:0]) - 8;
      if (run_disp == 0 || bias == 0) inv = !q[8];
      else inv = ((run_disp > 0) == (bias > 0));
      s = {inv, q[8], inv ? ~q[7:0] : q[7:0]};
      run_disp += 2 * $countones(s) - 10;
    end
  endtask

  task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic drive(input logic de, input logic [1:0] c, input logic [7:0] d);
    vid_en = de; sync_bits = c; pix_byte = d;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [9:0] exp_s;
    logic [9:0] pend [2];
    logic       pend_de [2];
    logic [7:0] pend_d [2];
    logic       prev_de;

    // R1: reset state
    rst = 1'b1;
    drive(1'b1, 2'b11, 8'hA5);
    repeat (3) @(negedge clk);
    check("R1 reset token", tmds_sym, 10'b1101010100);
    drive(1'b0, 2'b00, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run_disp = 0;
    seen_disp = 0;

    // table walk: entry i checked two negedges after it is driven
    prev_de = 1'b0;
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        logic [10:0] v;
        v = VEC[i-2];
        model_sym(v[10], v[9:8], v[7:0], exp_s);
        if (!v[10]) begin
          check("R3 blanking token", tmds_sym, exp_s);
          seen_disp = 0;
        end else begin
          check(v[9:8] != 2'b00 ? "R9 sync ignored in video" : "R8 data symbol",
                tmds_sym, exp_s);
          check("R4 decode to byte", {2'b00, b_decode(tmds_sym)}, {2'b00, v[7:0]});
          check("R5 chain flag", {9'd0, tmds_sym[8]}, {9'd0, b_chain(v[7:0]) >> 8});
          seen_disp += 2 * $countones(tmds_sym) - 10;
          checks++;
          if (seen_disp > 8 || seen_disp < -8) begin
            errors++;
            $display("FAIL R6 disparity actual=%0d expected=within +-8", seen_disp);
          end
          if (!prev_de)
            check("R7 first after blank", {9'd0, tmds_sym[9]}, {9'd0, ~tmds_sym[8]});
        end
        prev_de = v[10];
      end
      if (i < NV) drive(VEC[i][10], VEC[i][9:8], VEC[i][7:0]);
      else drive(1'b0, 2'b01, 8'h00);
    end

    // R2: latency from blanking into data
    repeat (3) @(negedge clk);
    run_disp = 0;
    drive(1'b1, 2'b10, 8'h10);
    @(negedge clk);
    drive(1'b1, 2'b10, 8'h33);
    check("R2 still token one clock later", tmds_sym, b_token(2'b01));
    @(negedge clk);
    drive(1'b0, 2'b11, 8'h33);
    model_sym(1'b1, 2'b10, 8'h10, exp_s);
    check("R2 data after two clocks", tmds_sym, exp_s);
    @(negedge clk);
    model_sym(1'b1, 2'b10, 8'h33, exp_s);
    check("R2 second data symbol", tmds_sym, exp_s);
    @(negedge clk);
    check("R2 sync aligned with blanking", tmds_sym, b_token(2'b11));

    // R1/R7: reset in the middle of video clears disparity
    drive(1'b1, 2'b00, 8'hFF);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 token after mid-run reset", tmds_sym, 10'b1101010100);
    rst = 1'b0;
    @(negedge clk);
    check("R1 token while pipeline refills", tmds_sym, 10'b1101010100);
    @(negedge clk);
    run_disp = 0;
    model_sym(1'b1, 2'b00, 8'hFF, exp_s);
    check("R7 disparity zero after reset", tmds_sym, exp_s);
    @(negedge clk);
    model_sym(1'b1, 2'b00, 8'hFF, exp_s);
    check("R8 second FF after reset", tmds_sym, exp_s);

    // R3: pixel data ignored in blanking
    drive(1'b0, 2'b10, 8'h00);
    @(negedge clk);
    drive(1'b0, 2'b10, 8'hFF);
    @(negedge clk);
    @(negedge clk);
    check("R3 data ignored, byte 00", tmds_sym, b_token(2'b10));
    @(negedge clk);
    check("R3 data ignored, byte FF", tmds_sym, b_token(2'b10));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule